// File: doc/BRIEF.md
# Ordered-Commit Synthesizer Parameter Registers

This block is a small indexed register file holding the four 8-bit loop parameters of a clock synthesizer. Software first writes a register number to an index port. It then reads or writes the selected register through a data port. The parameter set occupies register numbers C8h to CBh. C8h carries the VCO M divisor and C9h carries the low byte of the VCO N divisor. The other two complete the set.

Every parameter has one copy for each pipeline, and a pipeline-select input picks the copy that a data-port access reaches. Data writes only load staging registers. The values the synthesizer sees change only when one pipeline receives an unbroken, ascending write run C8h, C9h, CAh, CBh. On that last write all four committed bytes for that pipeline change in one clock, and a single-cycle update strobe marks the change. Because the synthesizer never sees a half-loaded set, its output cannot glitch while new values are being loaded.

Top module: `pll_param_regs`

## Requirements
- R1: A write at address 3D6h loads the 8-bit index register. A read at 3D6h returns the index. The index is 00h after reset.
- R2: A data write (address 3D7h) with the index in C8h..CBh stores the byte only in the staging copy that pipe_sel_i selects (0 = pipeline A, 1 = pipeline B). A data read returns that pipeline's staged byte for the current index.
- R3: For pipeline p, params_o bits [p*32 + r*8 +: 8] hold the committed byte of register C8h+r. These bits change only in the clock after a commit.
- R4: A pipeline commits when its CBh write directly follows its writes to C8h, C9h and CAh. All four committed bytes take the staged values, and the CBh byte just written is included in the same cycle.
- R5: update_o[p] is high for exactly the one cycle in which pipeline p's new committed values first appear. At all other times it is low.
- R6: A write to C8h starts the write run, or restarts it from the beginning if one is already in progress.
- R7: A write to a register of the set other than the one expected next aborts the run. The written byte is still staged, and there is no commit.
- R8: Data-port accesses while the index is outside C8h..CBh are ignored. They do not change staging, do not commit, and do not break a run in progress. Such reads return 00h.
- R9: Reads never change the state of any write run.
- R10: Each pipeline keeps its own write run. Accesses to the other pipeline neither advance nor abort it.
- R11: After reset, all staged and committed bytes are 00h, update_o is 0, and no write run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | I/O address of the access |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| pipe_sel_i | input | 1 | Pipeline copy targeted by data-port accesses |
| rdata_o | output | 8 | Read data (00h when not reading) |
| params_o | output | 64 | Committed parameters, 32 bits per pipeline |
| update_o | output | 2 | One-cycle commit strobe per pipeline |

## Verification
The closing CBh write lands in staging and triggers the commit in the same edge. The committed CBh byte must therefore come from the bus, not from the old staged value. Every swept four-write pattern writes a fresh byte at each step, so a commit that copied stale staging would show up as a params_o miscompare. The update strobe and the committed values change together. The bench checks both on the same sample, right after every write, against a model that tracks the expected run position of each pipeline.

// File: rtl/pll_param_pkg.sv
package pll_param_pkg;
  localparam int unsigned REG_W = 8;
  typedef logic [REG_W-1:0] reg_byte_t;
endpackage

// File: rtl/pll_idx_decode.sv
module pll_idx_decode #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 4,
  parameter logic [ADDR_W-1:0] IDX_ADDR = 'h3D6,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 'h3D7,
  parameter logic [DATA_W-1:0] BASE_IDX = 'hC8,
  localparam int unsigned OFF_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] idx_o,
  output logic              idx_sel_o,
  output logic              dat_sel_o,
  output logic              in_set_o,
  output logic [OFF_W-1:0]  off_o
);
  logic [DATA_W-1:0] idx_q;
  logic [DATA_W-1:0] rel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       idx_q <= '0;
    else if (wr_en_i && idx_sel_o)     idx_q <= wdata_i;
  end

  assign idx_sel_o = (addr_i == IDX_ADDR);
  assign dat_sel_o = (addr_i == DAT_ADDR);
  // wraps below base, so a single compare covers both bounds
  assign rel       = idx_q - BASE_IDX;
  assign in_set_o  = (rel < DATA_W'(NUM_REGS));
  assign off_o     = rel[OFF_W-1:0];
  assign idx_o     = idx_q;
endmodule

// File: rtl/pll_seq_track.sv
module pll_seq_track #(
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned OFF_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int unsigned CNT_W = $clog2(NUM_REGS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             fire_o
);
  // 0 = idle, k = offset k expected next
  logic [CNT_W-1:0] exp_q, exp_d;

  always_comb begin
    exp_d  = exp_q;
    fire_o = 1'b0;
    if (wr_i) begin
      if (off_i == '0) begin
        exp_d = CNT_W'(1);
      end else if (exp_q != '0 && CNT_W'(off_i) == exp_q) begin
        if (off_i == OFF_W'(NUM_REGS - 1)) begin
          fire_o = 1'b1;
          exp_d  = '0;
        end else begin
          exp_d = exp_q + CNT_W'(1);
        end
      end else begin
        exp_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exp_q <= '0;
    else         exp_q <= exp_d;
  end
endmodule

// File: rtl/pll_param_bank.sv
module pll_param_bank #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned OFF_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [OFF_W-1:0]           off_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       fire_i,
  output logic [NUM_REGS*DATA_W-1:0] stg_o,
  output logic [NUM_REGS*DATA_W-1:0] com_o,
  output logic                       upd_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] stg_q, com_q;
  logic                            upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
      com_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= fire_i;
      if (wr_i) stg_q[off_i] <= wdata_i;
      if (fire_i) begin
        for (int r = 0; r < NUM_REGS; r++) begin
          // closing write bypasses staging into the committed copy
          com_q[r] <= (wr_i && off_i == OFF_W'(r)) ? wdata_i : stg_q[r];
        end
      end
    end
  end

  assign stg_o = stg_q;
  assign com_o = com_q;
  assign upd_o = upd_q;
endmodule

// File: rtl/pll_param_regs.sv
module pll_param_regs
  import pll_param_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = REG_W,
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned NUM_PIPES = 2,
  parameter logic [ADDR_W-1:0] IDX_ADDR = 'h3D6,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 'h3D7,
  parameter logic [DATA_W-1:0] BASE_IDX = 'hC8,
  localparam int unsigned PSEL_W = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1,
  localparam int unsigned OFF_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int unsigned SET_W  = NUM_REGS * DATA_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       wr_en_i,
  input  logic                       rd_en_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [PSEL_W-1:0]          pipe_sel_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_PIPES*SET_W-1:0] params_o,
  output logic [NUM_PIPES-1:0]       update_o
);
  logic [DATA_W-1:0]                idx_q;
  logic                             idx_sel, dat_sel, in_set;
  logic [OFF_W-1:0]                 off;
  logic                             dat_wr;
  logic [NUM_PIPES-1:0][SET_W-1:0]  stg_all;

  pll_idx_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .IDX_ADDR(IDX_ADDR), .DAT_ADDR(DAT_ADDR), .BASE_IDX(BASE_IDX)
  ) u_dec (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i,
    .idx_o(idx_q), .idx_sel_o(idx_sel), .dat_sel_o(dat_sel),
    .in_set_o(in_set), .off_o(off)
  );

  assign dat_wr = wr_en_i && dat_sel && in_set;

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    logic wr_p, fire_p;
    assign wr_p = dat_wr && (pipe_sel_i == PSEL_W'(p));

    pll_seq_track #(.NUM_REGS(NUM_REGS)) u_trk (
      .clk_i, .rst_ni, .wr_i(wr_p), .off_i(off), .fire_o(fire_p)
    );

    pll_param_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
      .clk_i, .rst_ni, .wr_i(wr_p), .off_i(off), .wdata_i,
      .fire_i(fire_p), .stg_o(stg_all[p]),
      .com_o(params_o[p*SET_W +: SET_W]), .upd_o(update_o[p])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (idx_sel)              rdata_o = idx_q;
      else if (dat_sel && in_set) rdata_o = stg_all[pipe_sel_i][off*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/pll_param_regs_chk.sv
module pll_param_regs_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned NUM_PIPES = 2,
  parameter logic [ADDR_W-1:0] IDX_ADDR = 'h3D6,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 'h3D7,
  parameter logic [DATA_W-1:0] BASE_IDX = 'hC8
) (
  input logic                                clk_i,
  input logic                                rst_ni,
  input logic [ADDR_W-1:0]                   addr_i,
  input logic                                wr_en_i,
  input logic [DATA_W-1:0]                   wdata_i,
  input logic [DATA_W-1:0]                   idx_q,
  input logic [NUM_PIPES*NUM_REGS*DATA_W-1:0] params_o,
  input logic [NUM_PIPES-1:0]                update_o
);
  logic outside;
  assign outside = !((idx_q >= BASE_IDX) && ({1'b0, idx_q} < {1'b0, BASE_IDX} + (DATA_W+1)'(NUM_REGS)));

  a_r1_index_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == IDX_ADDR) |=> (idx_q == $past(wdata_i)));

  a_r3_hold_without_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_o == '0) |-> $stable(params_o));

  a_r5_single_cycle_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_o != '0) |=> (update_o == '0));

  a_r10_one_pipe_commits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(update_o));

  a_r8_outside_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == DAT_ADDR && outside) |=> (update_o == '0 && $stable(params_o)));

  a_r11_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (params_o == '0 && update_o == '0 && idx_q == '0));
endmodule

bind pll_param_regs pll_param_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_PIPES(NUM_PIPES),
  .IDX_ADDR(IDX_ADDR), .DAT_ADDR(DAT_ADDR), .BASE_IDX(BASE_IDX)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wdata_i(wdata_i), .idx_q(idx_q), .params_o(params_o), .update_o(update_o)
);

// File: tb/pll_param_regs_test.sv
`timescale 1ns/1ps
module pll_param_regs_test;
  localparam logic [15:0] IDX = 16'h3D6;
  localparam logic [15:0] DAT = 16'h3D7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic        psel = 1'b0;
  logic [7:0]  rdata;
  logic [63:0] params;
  logic [1:0]  update;

  int n_chk = 0, n_bad = 0, cycles = 0;
  logic [7:0] stg [2][4];
  logic [7:0] com [2][4];
  int         nxt [2];

  pll_param_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
    .wdata_i(wdata), .pipe_sel_i(psel), .rdata_o(rdata),
    .params_o(params), .update_o(update)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] packed_com();
    logic [63:0] v = '0;
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 4; r++) v[p*32 + r*8 +: 8] = com[p][r];
    return v;
  endfunction

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d, input logic ps);
    @(negedge clk);
    addr = a; wdata = d; psel = ps; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, input logic ps, output logic [7:0] d);
    @(negedge clk);
    addr = a; psel = ps; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  // writes one set register and checks strobe and committed values
  task automatic pwr(input int p, input int off, input logic [7:0] d);
    logic fire = 1'b0;
    bus_wr(IDX, 8'hC8 + 8'(off), 1'b0);
    bus_wr(DAT, d, 1'(p));
    stg[p][off] = d;
    if (off == 0) nxt[p] = 1;
    else if (nxt[p] != 0 && off == nxt[p]) begin
      if (off == 3) begin
        fire = 1'b1; nxt[p] = 0;
        for (int r = 0; r < 4; r++) com[p][r] = stg[p][r];
      end else nxt[p]++;
    end else nxt[p] = 0;
    chk("R5 update strobe", 64'(update), fire ? 64'(2'b01 << p) : 64'd0);
    chk("R4 committed params", params, packed_com());
  endtask

  task automatic readback_all(input string req);
    logic [7:0] d;
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 4; r++) begin
        bus_wr(IDX, 8'hC8 + 8'(r), 1'b0);
        bus_rd(DAT, 1'(p), d);
        chk(req, 64'(d), 64'(stg[p][r]));
      end
  endtask

  task automatic outside_access(input logic [7:0] oi, input logic [7:0] d);
    logic [7:0] r;
    bus_wr(IDX, oi, 1'b0);
    bus_rd(IDX, 1'b0, r);
    chk("R1 index readback", 64'(r), 64'(oi));
    bus_wr(DAT, d, 1'b0);
    chk("R8 outside write no strobe", 64'(update), 64'd0);
    chk("R8 outside write params", params, packed_com());
    bus_rd(DAT, 1'b1, r);
    chk("R8 outside read zero", 64'(r), 64'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    for (int p = 0; p < 2; p++) begin
      nxt[p] = 0;
      for (int r = 0; r < 4; r++) begin stg[p][r] = '0; com[p][r] = '0; end
    end
    repeat (3) @(negedge clk);
    chk("R11 reset params", params, 64'd0);
    chk("R11 reset strobe", 64'(update), 64'd0);
    rst_n = 1'b1;
    bus_rd(IDX, 1'b0, d);
    chk("R1 index after reset", 64'(d), 64'd0);
    readback_all("R11 staged zero");
    // R11: idle tracker, so starting at C9 must not commit
    pwr(0, 1, 8'h11); pwr(0, 2, 8'h22); pwr(0, 3, 8'h33);

    // R6 restart then complete
    pwr(0, 0, 8'hA0); pwr(0, 1, 8'hA1); pwr(0, 0, 8'hB0);
    pwr(0, 1, 8'hB1); pwr(0, 2, 8'hB2); pwr(0, 3, 8'hB3);

    // R9 reads mid-run, R8 outside accesses mid-run, then complete
    pwr(1, 0, 8'h5A);
    readback_all("R9 read mid-run");
    pwr(1, 1, 8'h5B);
    outside_access(8'hC7, 8'hEE);
    outside_access(8'hCC, 8'hDD);
    pwr(1, 2, 8'h5C); pwr(1, 3, 8'h5D);

    // R10 interleaved pipelines both complete
    for (int k = 0; k < 4; k++) begin
      pwr(0, k, 8'h60 + 8'(k));
      pwr(1, k, 8'h70 + 8'(k));
    end

    // R7/R2/R4 sweep of every four-write offset pattern on both pipes
    for (int p = 0; p < 2; p++)
      for (int pat = 0; pat < 256; pat++) begin
        for (int k = 0; k < 4; k++)
          pwr(p, (pat >> (2*k)) & 3, 8'((pat*7 + k*53 + p*101 + 1) & 8'hFF));
        if (pat % 16 == 0) readback_all("R2 staged readback");
        if (pat % 37 == 0) outside_access(8'(pat), 8'(pat ^ 8'h5A));
      end
    readback_all("R7 final staged readback");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule